// File: doc/BRIEF.md
# SPI Word-Register Access Target

This block is an SPI target, clocked from the system clock, that gives a host controller read and write access to a word-addressed register space. Every chip-select frame begins with a 32-bit command word. The command gives the direction, a read word count and a starting word address. A payload of 32-bit words follows it. On a write, each complete payload word becomes one write strobe on a simple synchronous register bus, and the address steps up by one per word. On a read, the block fetches words from the register bus ahead of time and shifts them out behind the command word, with the address stepping up in the same way.

SCLK, chip select and MOSI are brought into the system clock domain through a synchronizer, and their edges are detected there. SCLK must therefore run several times slower than the system clock. The register file on the far side sees one-cycle read and write strobes with an address. It returns read data in the cycle after the read strobe. A sticky error output records every word that was dropped or zero-filled because it fell outside the implemented space or the payload limit.

Top module: `spi_wreg_target`

## Requirements
- R1: SPI mode 0, most significant bit first. MOSI is sampled on the rising SCLK edge and MISO changes after the falling edge. MISO is 0 while chip select is high.
- R2: Command word layout: bit 31 is 1 for write and 0 for read. Bits 30:25 are the read word count, where 0 means 64. Bits 24:4 are the starting word address. Bits 3:0 are ignored.
- R3: In a write frame, each complete payload word k gives exactly one one-cycle `reg_wr` pulse, with `reg_addr` = start + k and `reg_wdata` = that word.
- R4: A trailing partial word, ended by chip select going high before its 32nd bit, is discarded and no write is issued.
- R5: In a read frame, payload word k returns the register at start + k. MISO stays 0 for the whole command word.
- R6: Each register fetch is a single-cycle `reg_rd` pulse. `reg_rdata` is taken in the following cycle. `reg_rd` and `reg_wr` are never high together.
- R7: Read payload words past the requested count are returned as zero, with no bus read and no error.
- R8: A requested word whose address is at or above REG_WORDS is not accessed: a read returns zero and a write is dropped. In both cases `frame_err` is set.
- R9: Payload words from index 64 onward are not accessed (zero on read, dropped on write) and set `frame_err`. A frame of exactly 64 words is legal.
- R10: `frame_err` stays set until reset. After reset, `frame_err`, `reg_wr`, `reg_rd` and MISO are all 0.
- R11: Chip select going high at any point abandons the frame. The next frame starts again with a command word.
- R12: The count field of a write command has no effect, and MISO stays 0 throughout a write frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| reg_addr | output | 21 | Register word address |
| reg_wdata | output | 32 | Register write data |
| reg_wr | output | 1 | Write strobe, one cycle |
| reg_rd | output | 1 | Read strobe, one cycle |
| reg_rdata | input | 32 | Read data, valid the cycle after `reg_rd` |
| frame_err | output | 1 | Sticky error for dropped or zero-filled words |

## Verification
A wrong bit counter or command latch shows up in the same frame as a wrong write address or data word, or as a payload word shifted by a bit position, so the host comparison catches it within one word. If address stepping or word indexing goes wrong, the wrong register is hit or the zero fill starts at the wrong word, typically from the second payload word on. An error flag that sets on the legal 64-word boundary, or fails to set one word later, can be seen on `frame_err` right after the frame that crosses that boundary. A chip-select restart fault corrupts the frame that follows an aborted one.

// File: rtl/spi_wreg_pkg.sv
package spi_wreg_pkg;

    localparam int WORD_W      = 32;
    localparam int HDR_ADDR_W  = 21;
    localparam int HDR_CNT_W   = 6;
    // bits of the command word that carry decoded fields (31 down to 4)
    localparam int HDR_FIELD_BITS = 1 + HDR_CNT_W + HDR_ADDR_W;

    typedef enum logic {
        PH_HDR = 1'b0,
        PH_PAY = 1'b1
    } phase_e;

    // decoded view of the upper 28 command bits, MSB first
    typedef struct packed {
        logic                  wr;
        logic [HDR_CNT_W-1:0]  cnt;
        logic [HDR_ADDR_W-1:0] addr;
    } hdr_t;

endpackage

// File: rtl/spi_wreg_sync.sv
module spi_wreg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_act,
    output logic mosi_s
);

    localparam int LINES = 3;
    localparam logic [LINES-1:0] IDLE = 3'b010;

    logic [LINES-1:0] stg_d [STAGES];
    logic [LINES-1:0] stg_q [STAGES];
    logic [LINES-1:0] last;
    logic             sclk_d, sclk_q;

    always_comb begin
        stg_d[0] = {sclk, cs_n, mosi};
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    assign last   = stg_q[STAGES-1];
    assign sclk_d = last[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stg_q[s] <= IDLE;
            end
            sclk_q <= 1'b0;
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stg_q[s] <= stg_d[s];
            end
            sclk_q <= sclk_d;
        end
    end

    assign sclk_rise = last[2] & ~sclk_q;
    assign sclk_fall = ~last[2] & sclk_q;
    assign cs_act    = ~last[1];
    assign mosi_s    = last[0];

endmodule

// File: rtl/spi_wreg_rx.sv
module spi_wreg_rx
    import spi_wreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sclk_rise,
    input  logic              mosi_s,
    output logic [WORD_W-1:0] rx_word,
    output logic [4:0]        rx_bits,
    output logic              rx_tick,
    output logic              rx_done
);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [4:0]        bits;
        logic              tick;
        logic              done;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d      = rx_q;
        rx_d.tick = 1'b0;
        rx_d.done = 1'b0;
        if (!cs_act) begin
            rx_d.word = '0;
            rx_d.bits = '0;
        end else if (sclk_rise) begin
            rx_d.word = {rx_q.word[WORD_W-2:0], mosi_s};
            rx_d.bits = rx_q.bits + 5'd1;
            rx_d.tick = 1'b1;
            rx_d.done = (rx_q.bits == 5'd31);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign rx_word = rx_q.word;
    assign rx_bits = rx_q.bits;
    assign rx_tick = rx_q.tick;
    assign rx_done = rx_q.done;

endmodule

// File: rtl/spi_wreg_ctrl.sv
module spi_wreg_ctrl
    import spi_wreg_pkg::*;
#(
    parameter int REG_WORDS = 256,
    parameter int MAX_WORDS = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_act,
    input  logic                  sclk_fall,
    input  logic [WORD_W-1:0]     rx_word,
    input  logic [4:0]            rx_bits,
    input  logic                  rx_tick,
    input  logic                  rx_done,
    input  logic [WORD_W-1:0]     reg_rdata,
    output logic [HDR_ADDR_W-1:0] reg_addr,
    output logic [WORD_W-1:0]     reg_wdata,
    output logic                  reg_wr,
    output logic                  reg_rd,
    output logic                  miso,
    output logic                  frame_err
);

    localparam int IDX_W = $clog2(MAX_WORDS + 1);
    localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(MAX_WORDS);
    localparam logic [HDR_ADDR_W:0] ADDR_LIMIT = (HDR_ADDR_W+1)'(REG_WORDS);

    typedef struct packed {
        phase_e                ph;
        logic                  is_wr;
        logic [IDX_W-1:0]      req;
        logic [HDR_ADDR_W-1:0] addr;
        logic [IDX_W-1:0]      widx;
        logic [IDX_W-1:0]      fidx;
        logic [WORD_W-1:0]     hold;
        logic [WORD_W-1:0]     tx;
        logic                  ld_pend;
        logic                  cap;
        logic                  bus_wr;
        logic                  bus_rd;
        logic [HDR_ADDR_W-1:0] bus_addr;
        logic [WORD_W-1:0]     bus_wdata;
        logic                  err;
    } ctl_t;

    ctl_t q, n;

    function automatic logic in_range(input logic [HDR_ADDR_W-1:0] a);
        return ({1'b0, a} < ADDR_LIMIT);
    endfunction

    function automatic logic [IDX_W-1:0] sat_inc(input logic [IDX_W-1:0] v);
        return (v >= IDX_MAX) ? v : v + 1'b1;
    endfunction

    hdr_t                  hdr_w;
    logic                  in_hdr;
    logic                  addr_pt;
    logic                  f_go;
    logic [HDR_ADDR_W-1:0] f_addr;
    logic [IDX_W-1:0]      f_idx;
    logic [IDX_W-1:0]      f_req;
    logic [IDX_W-1:0]      req_hdr;

    assign hdr_w   = hdr_t'(rx_word[HDR_FIELD_BITS-1:0]);
    assign in_hdr  = (q.ph == PH_HDR);
    assign addr_pt = rx_tick && (rx_bits == 5'(HDR_FIELD_BITS));
    assign req_hdr = (hdr_w.cnt == '0) ? IDX_MAX : IDX_W'(hdr_w.cnt);
    assign f_go    = addr_pt && (in_hdr ? !hdr_w.wr : !q.is_wr);
    assign f_addr  = in_hdr ? hdr_w.addr : q.addr;
    assign f_idx   = in_hdr ? '0 : q.fidx;
    assign f_req   = in_hdr ? req_hdr : q.req;

    always_comb begin
        n        = q;
        n.bus_wr = 1'b0;
        n.bus_rd = 1'b0;
        n.cap    = q.bus_rd;
        if (q.cap) n.hold = reg_rdata;

        if (!cs_act) begin
            n.ph      = PH_HDR;
            n.widx    = '0;
            n.fidx    = '0;
            n.tx      = '0;
            n.hold    = '0;
            n.ld_pend = 1'b0;
        end else begin
            // command fields are complete once bit 4 has arrived
            if (addr_pt && in_hdr) begin
                n.is_wr = hdr_w.wr;
                n.req   = req_hdr;
                n.addr  = hdr_w.addr;
            end

            // prefetch of the next read word, four bits before the boundary
            if (f_go) begin
                n.hold = '0;
                if (f_idx < f_req && f_idx < IDX_MAX) begin
                    if (in_range(f_addr)) begin
                        n.bus_rd   = 1'b1;
                        n.bus_addr = f_addr;
                    end else begin
                        n.err = 1'b1;
                    end
                end
                n.addr = f_addr + 1'b1;
                n.fidx = sat_inc(f_idx);
            end

            // a payload word beyond the frame limit has started
            if (rx_tick && rx_bits == 5'd1 && !in_hdr && q.widx >= IDX_MAX) begin
                n.err = 1'b1;
            end

            if (rx_done) begin
                n.ld_pend = !q.is_wr;
                if (in_hdr) begin
                    n.ph = PH_PAY;
                end else begin
                    if (q.is_wr) begin
                        if (q.widx < IDX_MAX) begin
                            if (in_range(q.addr)) begin
                                n.bus_wr    = 1'b1;
                                n.bus_addr  = q.addr;
                                n.bus_wdata = rx_word;
                            end else begin
                                n.err = 1'b1;
                            end
                        end
                        n.addr = q.addr + 1'b1;
                    end
                    n.widx = sat_inc(q.widx);
                end
            end

            if (sclk_fall) begin
                if (q.ld_pend) begin
                    n.tx      = q.hold;
                    n.ld_pend = 1'b0;
                end else begin
                    n.tx = {q.tx[WORD_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign reg_addr  = q.bus_addr;
    assign reg_wdata = q.bus_wdata;
    assign reg_wr    = q.bus_wr;
    assign reg_rd    = q.bus_rd;
    assign miso      = cs_act & q.tx[WORD_W-1];
    assign frame_err = q.err;

endmodule

// File: rtl/spi_wreg_target.sv
module spi_wreg_target
    import spi_wreg_pkg::*;
#(
    parameter int REG_WORDS   = 256,
    parameter int MAX_WORDS   = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  spi_sclk,
    input  logic                  spi_cs_n,
    input  logic                  spi_mosi,
    output logic                  spi_miso,
    output logic [HDR_ADDR_W-1:0] reg_addr,
    output logic [WORD_W-1:0]     reg_wdata,
    output logic                  reg_wr,
    output logic                  reg_rd,
    input  logic [WORD_W-1:0]     reg_rdata,
    output logic                  frame_err
);

    logic              sclk_rise, sclk_fall, cs_act, mosi_s;
    logic [WORD_W-1:0] rx_word;
    logic [4:0]        rx_bits;
    logic              rx_tick, rx_done;

    spi_wreg_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (spi_sclk),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_act    (cs_act),
        .mosi_s    (mosi_s)
    );

    spi_wreg_rx rx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .mosi_s    (mosi_s),
        .rx_word   (rx_word),
        .rx_bits   (rx_bits),
        .rx_tick   (rx_tick),
        .rx_done   (rx_done)
    );

    spi_wreg_ctrl #(.REG_WORDS(REG_WORDS), .MAX_WORDS(MAX_WORDS)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sclk_fall (sclk_fall),
        .rx_word   (rx_word),
        .rx_bits   (rx_bits),
        .rx_tick   (rx_tick),
        .rx_done   (rx_done),
        .reg_rdata (reg_rdata),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .miso      (spi_miso),
        .frame_err (frame_err)
    );

endmodule

// File: rtl/spi_wreg_chk.sv
module spi_wreg_chk #(
    parameter int REG_WORDS = 256
) (
    input logic        clk,
    input logic        rst_n,
    input logic        spi_cs_n,
    input logic        spi_miso,
    input logic [20:0] reg_addr,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic        frame_err
);

    localparam logic [21:0] LIMIT = 22'(REG_WORDS);

    // R1
    miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso);

    // R3
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    // R6
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    // R6
    bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));

    // R8
    bus_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr || reg_rd) |-> ({1'b0, reg_addr} < LIMIT));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);

endmodule

bind spi_wreg_target spi_wreg_chk #(.REG_WORDS(REG_WORDS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_cs_n  (spi_cs_n),
    .spi_miso  (spi_miso),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .frame_err (frame_err)
);

// File: tb/spi_wreg_target_tb_top.sv
`timescale 1ns/1ps
module spi_wreg_target_tb_top;

    localparam int HALF      = 5;
    localparam int REG_WORDS = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic [20:0] reg_addr;
    logic [31:0] reg_wdata;
    logic        reg_wr, reg_rd, frame_err;
    logic [31:0] reg_rdata;

    logic [31:0] mem [REG_WORDS];
    int          wr_cnt, rd_cnt;
    int          vectors = 0;
    int          errs = 0;

    always #2.5 clk = ~clk;

    spi_wreg_target #(.REG_WORDS(REG_WORDS)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sclk  (spi_sclk),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata),
        .frame_err (frame_err)
    );

    function automatic logic [31:0] pat(input int i);
        return {8'h5A, 8'(i), 8'(~i), 8'(i * 3)};
    endfunction

    // register file model: one-cycle read latency
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_WORDS; i++) mem[i] <= pat(i);
            reg_rdata <= '0;
            wr_cnt    <= 0;
            rd_cnt    <= 0;
        end else begin
            if (reg_wr) begin
                if (reg_addr < 21'(REG_WORDS)) mem[reg_addr[7:0]] <= reg_wdata;
                wr_cnt <= wr_cnt + 1;
            end
            if (reg_rd) begin
                reg_rdata <= (reg_addr < 21'(REG_WORDS)) ? mem[reg_addr[7:0]] : 32'hDEAD_BEEF;
                rd_cnt    <= rd_cnt + 1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] hdr(input bit wr, input logic [5:0] cnt,
                                        input logic [20:0] a, input logic [3:0] lo);
        return {wr, cnt, a, lo};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; spi_cs_n = 1'b1; spi_sclk = 1'b0; spi_mosi = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic cs_on();
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_off();
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (4 * HALF) @(negedge clk);
    endtask

    task automatic xfer(input logic [31:0] tx, input int nb, output logic [31:0] rx);
        rx = '0;
        for (int i = 0; i < nb; i++) begin
            spi_mosi = tx[31-i];
            repeat (HALF) @(negedge clk);
            rx = {rx[30:0], spi_miso};
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic t_reset();
        check("R10 miso after reset", 32'(spi_miso), 32'd0);
        check("R10 reg_wr after reset", 32'(reg_wr), 32'd0);
        check("R10 reg_rd after reset", 32'(reg_rd), 32'd0);
        check("R10 frame_err after reset", 32'(frame_err), 32'd0);
    endtask

    task automatic t_write();
        logic [31:0] rx;
        int w0;
        w0 = wr_cnt;
        cs_on();
        xfer(hdr(1'b1, 6'h15, 21'h10, 4'hF), 32, rx);
        check("R12 miso in write header", rx, 32'd0);
        for (int k = 0; k < 3; k++) begin
            xfer(32'hC0DE_0000 + 32'(k), 32, rx);
            check("R12 miso in write payload", rx, 32'd0);
        end
        cs_off();
        for (int k = 0; k < 3; k++) check("R3 written word", mem[8'h10 + k], 32'hC0DE_0000 + 32'(k));
        check("R3 write strobe count", 32'(wr_cnt - w0), 32'd3);
        check("R2 neighbour untouched", mem[8'h13], pat(8'h13));
    endtask

    task automatic t_read();
        logic [31:0] rx;
        int r0;
        r0 = rd_cnt;
        cs_on();
        xfer(hdr(1'b0, 6'd3, 21'h10, 4'h0), 32, rx);
        check("R5 miso zero in header", rx, 32'd0);
        for (int k = 0; k < 3; k++) begin
            xfer(32'h0, 32, rx);
            check("R5 read word", rx, 32'hC0DE_0000 + 32'(k));
        end
        cs_off();
        check("R6 read strobe count", 32'(rd_cnt - r0), 32'd3);
        cs_on();
        xfer(hdr(1'b0, 6'd4, 21'h40, 4'hA), 32, rx);
        for (int k = 0; k < 4; k++) begin
            xfer(32'hFFFF_FFFF, 32, rx);
            check("R2 R1 read with ignored low bits", rx, pat(8'h40 + k));
        end
        cs_off();
    endtask

    task automatic t_partial();
        logic [31:0] rx;
        int w0;
        w0 = wr_cnt;
        cs_on();
        xfer(hdr(1'b1, 6'd0, 21'h30, 4'h0), 32, rx);
        xfer(32'h1111_1111, 32, rx);
        xfer(32'h2222_2222, 32, rx);
        xfer(32'h3333_3333, 12, rx);
        cs_off();
        check("R4 full words written", mem[8'h31], 32'h2222_2222);
        check("R4 partial word dropped", mem[8'h32], pat(8'h32));
        check("R4 strobe count", 32'(wr_cnt - w0), 32'd2);
    endtask

    task automatic t_short_read();
        logic [31:0] rx;
        int r0;
        r0 = rd_cnt;
        cs_on();
        xfer(hdr(1'b0, 6'd2, 21'h50, 4'h0), 32, rx);
        for (int k = 0; k < 4; k++) begin
            xfer(32'h0, 32, rx);
            check("R7 read beyond count", rx, (k < 2) ? pat(8'h50 + k) : 32'd0);
        end
        cs_off();
        check("R7 bus reads", 32'(rd_cnt - r0), 32'd2);
        check("R7 no error", 32'(frame_err), 32'd0);
    endtask

    task automatic t_abort();
        logic [31:0] rx;
        cs_on();
        xfer(32'hFFFF_FFFF, 13, rx);
        cs_off();
        cs_on();
        xfer(hdr(1'b1, 6'd0, 21'h70, 4'h0), 32, rx);
        xfer(32'hABCD_0001, 20, rx);
        cs_off();
        cs_on();
        xfer(hdr(1'b0, 6'd1, 21'h60, 4'h0), 32, rx);
        xfer(32'h0, 32, rx);
        cs_off();
        check("R11 frame after abort", rx, pat(8'h60));
        check("R11 aborted write dropped", mem[8'h70], pat(8'h70));
    endtask

    task automatic t_past_end();
        logic [31:0] rx;
        int r0, w0;
        r0 = rd_cnt;
        cs_on();
        xfer(hdr(1'b0, 6'd4, 21'd254, 4'h0), 32, rx);
        for (int k = 0; k < 4; k++) begin
            xfer(32'h0, 32, rx);
            check("R8 read near end", rx, (k < 2) ? pat(254 + k) : 32'd0);
        end
        cs_off();
        check("R8 bus reads", 32'(rd_cnt - r0), 32'd2);
        check("R8 error set by read", 32'(frame_err), 32'd1);
        cs_on();
        xfer(hdr(1'b0, 6'd1, 21'h5, 4'h0), 32, rx);
        xfer(32'h0, 32, rx);
        cs_off();
        check("R10 error stays set", 32'(frame_err), 32'd1);
        do_reset();
        check("R10 error cleared by reset", 32'(frame_err), 32'd0);
        w0 = wr_cnt;
        cs_on();
        xfer(hdr(1'b1, 6'd0, 21'd255, 4'h0), 32, rx);
        xfer(32'h7777_0001, 32, rx);
        xfer(32'h7777_0002, 32, rx);
        cs_off();
        check("R8 last word written", mem[255], 32'h7777_0001);
        check("R8 write strobes", 32'(wr_cnt - w0), 32'd1);
        check("R8 error set by write", 32'(frame_err), 32'd1);
    endtask

    task automatic t_limit();
        logic [31:0] rx;
        int w0;
        do_reset();
        cs_on();
        xfer(hdr(1'b0, 6'd0, 21'd0, 4'h0), 32, rx);
        for (int k = 0; k < 64; k++) begin
            xfer(32'h0, 32, rx);
            check("R9 R2 64-word read", rx, pat(k));
        end
        cs_off();
        check("R9 no error at 64 words", 32'(frame_err), 32'd0);
        cs_on();
        xfer(hdr(1'b0, 6'd0, 21'd0, 4'h0), 32, rx);
        for (int k = 0; k < 65; k++) xfer(32'h0, 32, rx);
        cs_off();
        check("R9 word 64 zero", rx, 32'd0);
        check("R9 error after 65 read words", 32'(frame_err), 32'd1);
        do_reset();
        w0 = wr_cnt;
        cs_on();
        xfer(hdr(1'b1, 6'd0, 21'd100, 4'h0), 32, rx);
        for (int k = 0; k < 65; k++) xfer(32'h9000_0000 + 32'(k), 32, rx);
        cs_off();
        check("R9 write strobes", 32'(wr_cnt - w0), 32'd64);
        check("R9 word 63 written", mem[163], 32'h9000_003F);
        check("R9 word 64 dropped", mem[164], pat(164));
        check("R9 error after 65 write words", 32'(frame_err), 32'd1);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_write();
        t_read();
        t_partial();
        t_short_read();
        t_abort();
        t_past_end();
        t_limit();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

endmodule